// File: doc/BRIEF.md
# Chopper and Auto-Zero Clock Generator

This block turns one master clock into the full set of switching clocks for a chopper-stabilised amplifier whose two parallel branches are auto-zeroed in alternation. It produces a chopper clock and one storing phase per branch. While a branch's phase is high, that branch stores its offset. While it is low, the branch amplifies. The auto-zero period is exactly eight chopper periods, and every auto-zero edge lands on a chopper edge.

It also drives a switched-capacitor low-pass filter with two non-overlapping phases. A two-bit select picks the filter's bandwidth: 00 gives 5 kHz, 01 gives 1 kHz, 10 gives 200 Hz and 11 gives 10 Hz. The filter clock is a fixed multiple of the chosen bandwidth, so the period ratios are 1 : 5 : 25 : 500. A new select value is adopted only at the end of the filter period in progress. A ready flag tells downstream logic when every divider has completed one full cycle.

Top module: `chopaz_clock_gen`

## Requirements
- R1: While `rst_n` is low, `chop_clk`, both bits of `az_store`, `flt_ph1`, `flt_ph2` and `ready` are all 0.
- R2: `chop_clk` starts at 0 and toggles on every CHOP_HALF-th rising master edge after reset is released. Its period is therefore 2*CHOP_HALF master cycles.
- R3: Chopper half-periods are numbered h = 0, 1, 2 ... from reset, and the auto-zero position is h mod 16. Bit 0 of `az_store` is high at positions 1..7 and bit 1 at positions 9..15. Every change of `az_store` coincides with a change of `chop_clk`.
- R4: The two `az_store` bits are never high together. At positions 0 and 8 both are low, so both branches amplify.
- R5: The filter period in master cycles is FLT_BASE times 1, 5, 25 or 500 for select 00, 01, 10 or 11 respectively.
- R6: Let f be the position within a filter period of length P, with f running from 0 to P-1. `flt_ph1` is high for DEAD <= f < P/2 (P/2 rounded down). `flt_ph2` is high for f >= P/2 + DEAD. Otherwise both are low, which leaves a gap of at least DEAD cycles between the phases.
- R7: The select is sampled only on the edge that ends a filter period, so a change in mid-period leaves that period at its old length. The first period after reset uses the rate of select 00.
- R8: `ready` rises once the first 16-half-period auto-zero cycle and the first filter period have both completed. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bw_sel | input | 2 | Filter bandwidth select (00 widest, 11 narrowest) |
| chop_clk | output | 1 | Chopper clock |
| az_store | output | 2 | Per-branch auto-zero storing phase, bit b for branch b |
| flt_ph1 | output | 1 | First non-overlapping filter phase |
| flt_ph2 | output | 1 | Second non-overlapping filter phase |
| ready | output | 1 | All dividers have completed one full period |

## Verification
The hardest situation to reach is a select change that arrives in the middle of a long filter period. The stretch of that period still to run must complete at the old length, and only the next period may switch rate. The stimulus settles at the narrowest bandwidth, waits for a rising edge of the first phase, and then switches to the widest bandwidth about a hundred cycles into a 4000-cycle period. It then times the following two rising edges. A second phase toggles the select every few dozen cycles, so that changes land at many positions inside short periods, including the final cycle. A behavioural model is compared against the design on every clock throughout.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  // Filter period multiplier for each bandwidth code (5k/1k/200/10 Hz)
  function automatic int unsigned bw_ratio(input logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 5;
      2'b10:   return 25;
      default: return 500;
    endcase
  endfunction

  // Branch b stores in the open window (b*seg, (b+1)*seg) of half-periods
  function automatic logic az_window(input int h, input int b, input int seg);
    return (h > b * seg) && (h < (b + 1) * seg);
  endfunction

endpackage

// File: rtl/chop_divider.sv
module chop_divider
  import clkgen_pkg::*;
#(
  parameter int CHOP_HALF       = 4,
  parameter int AZ_CHOP_PERIODS = 8,
  parameter int BRANCHES        = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                chop,
  output logic [BRANCHES-1:0] az_q,
  output logic                az_wrap
);
  localparam int AZ_HALVES = 2 * AZ_CHOP_PERIODS;
  localparam int SEG       = AZ_HALVES / BRANCHES;
  localparam int CW        = $clog2(CHOP_HALF + 1);
  localparam int HW        = $clog2(AZ_HALVES);

  logic [CW-1:0]       cnt;
  logic [HW-1:0]       hidx, hnext;
  logic                tick;
  logic [BRANCHES-1:0] az_nxt;

  assign tick    = (cnt == CW'(CHOP_HALF - 1));
  assign hnext   = (hidx == HW'(AZ_HALVES - 1)) ? '0 : hidx + 1'b1;
  assign az_wrap = tick && (hidx == HW'(AZ_HALVES - 1));

  for (genvar b = 0; b < BRANCHES; b++) begin : g_branch
    assign az_nxt[b] = az_window(int'(hnext), b, SEG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hidx <= '0;
      chop <= 1'b0;
      az_q <= '0;
    end else if (tick) begin
      cnt  <= '0;
      chop <= ~chop;
      hidx <= hnext;
      az_q <= az_nxt;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_chop_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (chop != $past(chop)));
  p_chop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(chop));
  p_az_on_chop_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (az_q != $past(az_q)) |-> (chop != $past(chop)));
  p_single_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(az_q));

endmodule

// File: rtl/nov_phase_gen.sv
module nov_phase_gen
  import clkgen_pkg::*;
#(
  parameter int FLT_BASE = 8,
  parameter int DEAD     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       ph1,
  output logic       ph2,
  output logic       fwrap
);
  localparam int PMAX = FLT_BASE * 500;
  localparam int FW   = $clog2(PMAX + 1);

  function automatic logic [FW-1:0] period_of(input logic [1:0] s);
    return FW'(FLT_BASE * bw_ratio(s));
  endfunction

  logic [FW-1:0] fcnt, nxt_cnt, cur_p, nxt_p;
  logic [1:0]    sel_act, nxt_sel;

  assign cur_p   = period_of(sel_act);
  assign fwrap   = (fcnt == cur_p - 1'b1);
  assign nxt_cnt = fwrap ? '0 : fcnt + 1'b1;
  assign nxt_sel = fwrap ? sel : sel_act;
  assign nxt_p   = period_of(nxt_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt    <= '0;
      sel_act <= 2'b00;
      ph1     <= 1'b0;
      ph2     <= 1'b0;
    end else begin
      fcnt    <= nxt_cnt;
      sel_act <= nxt_sel;
      ph1     <= (nxt_cnt >= FW'(DEAD)) && (nxt_cnt < (nxt_p >> 1));
      ph2     <= (nxt_cnt >= (nxt_p >> 1) + FW'(DEAD));
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1 && ph2));
  p_gap_after_ph1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph1) |-> !ph2);
  p_gap_after_ph2_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ph2) |-> !ph1);
  p_rise_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph1) |-> (fcnt == FW'(DEAD)));
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fwrap |=> $stable(sel_act));
  p_period_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwrap |=> (fcnt == '0));

endmodule

// File: rtl/chopaz_clock_gen.sv
module chopaz_clock_gen #(
  parameter int CHOP_HALF = 4,
  parameter int FLT_BASE  = 8,
  parameter int DEAD      = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bw_sel,
  output logic       chop_clk,
  output logic [1:0] az_store,
  output logic       flt_ph1,
  output logic       flt_ph2,
  output logic       ready
);
  logic az_wrap, fwrap;
  logic az_done, flt_done;

  chop_divider #(
    .CHOP_HALF(CHOP_HALF), .AZ_CHOP_PERIODS(8), .BRANCHES(2)
  ) u_chop (
    .clk(clk), .rst_n(rst_n), .chop(chop_clk), .az_q(az_store), .az_wrap(az_wrap)
  );

  nov_phase_gen #(
    .FLT_BASE(FLT_BASE), .DEAD(DEAD)
  ) u_flt (
    .clk(clk), .rst_n(rst_n), .sel(bw_sel), .ph1(flt_ph1), .ph2(flt_ph2), .fwrap(fwrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      az_done  <= 1'b0;
      flt_done <= 1'b0;
    end else begin
      if (az_wrap) az_done  <= 1'b1;
      if (fwrap)   flt_done <= 1'b1;
    end
  end

  assign ready = az_done & flt_done;

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_ready_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(az_wrap) || $past(fwrap)));

endmodule

// File: tb/test_chopaz_clock_gen.sv
module test_chopaz_clock_gen;
  localparam int CH   = 4;
  localparam int FB   = 8;
  localparam int DT   = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bw_sel = 2'b00;
  logic chop_clk, flt_ph1, flt_ph2, ready;
  logic [1:0] az_store;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int n = 0, f = 0, fdone = 0;
  logic [1:0] sa = 2'b00;

  always #5 clk = ~clk;

  chopaz_clock_gen #(.CHOP_HALF(CH), .FLT_BASE(FB), .DEAD(DT)) i_chopaz_clock_gen (
    .clk(clk), .rst_n(rst_n), .bw_sel(bw_sel), .chop_clk(chop_clk),
    .az_store(az_store), .flt_ph1(flt_ph1), .flt_ph2(flt_ph2), .ready(ready)
  );

  function automatic int ref_period(input logic [1:0] s);
    int m;
    if (s == 2'b00) m = 1;
    else if (s == 2'b01) m = 5;
    else if (s == 2'b10) m = 25;
    else m = 500;
    return FB * m;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Behavioural reference, advanced on each master edge
  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; f = 0; sa = 2'b00; fdone = 0;
    end else begin
      n++;
      if (f == ref_period(sa) - 1) begin
        f = 0; sa = bw_sel; fdone = 1;
      end else f++;
    end
  end

  // Compare on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int h, pos, p;
      h = n / CH;
      pos = h % 16;
      p = ref_period(sa);
      chk("R2 chopper level", int'(chop_clk), h % 2);
      chk("R3 branch0 store", int'(az_store[0]), int'(pos >= 1 && pos <= 7));
      chk("R3 branch1 store", int'(az_store[1]), int'(pos >= 9));
      chk("R4 both storing", int'(az_store == 2'b11), 0);
      chk("R6 phase1", int'(flt_ph1), int'(f >= DT && f < p / 2));
      chk("R6 phase2", int'(flt_ph2), int'(f >= p / 2 + DT));
      chk("R8 ready", int'(ready), int'(n >= 16 * CH && fdone == 1));
    end
  end

  task automatic wait_rise(output int t);
    logic last;
    bit seen;
    last = flt_ph1;
    seen = 0;
    while (!seen) begin
      @(negedge clk);
      if (flt_ph1 && !last) seen = 1;
      last = flt_ph1;
    end
    t = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t0, t1, t2;
    repeat (3) @(negedge clk);
    // R1: outputs held low in reset
    chk("R1 reset chop", int'(chop_clk), 0);
    chk("R1 reset az", int'(az_store), 0);
    chk("R1 reset ph1", int'(flt_ph1), 0);
    chk("R1 reset ph2", int'(flt_ph2), 0);
    chk("R1 reset ready", int'(ready), 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);

    // R5: period per select
    for (int s = 0; s < 4; s++) begin
      bw_sel = 2'(s);
      wait_rise(t0); wait_rise(t0); wait_rise(t0);
      wait_rise(t1);
      chk($sformatf("R5 period sel=%0d", s), t1 - t0, ref_period(2'(s)));
    end

    // R7: change in mid-period of the slowest rate
    wait_rise(t0);
    repeat (100) @(negedge clk);
    bw_sel = 2'b00;
    wait_rise(t1);
    chk("R7 old period kept", t1 - t0, ref_period(2'b11));
    wait_rise(t2);
    chk("R7 new period used", t2 - t1, ref_period(2'b00));

    // Frequent select changes at many positions
    for (int k = 0; k < 120; k++) begin
      bw_sel = 2'(k % 3);
      repeat (13 + (k % 29)) @(negedge clk);
    end
    bw_sel = 2'b00;
    repeat (600) @(negedge clk);

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset ready", int'(ready), 0);
    chk("R1 re-reset outputs", int'({chop_clk, az_store, flt_ph1, flt_ph2}), 0);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    finish_run();
  end

endmodule